// File: doc/BRIEF.md
# Tone Bus Command Transmitter

This block sends satellite-switch control commands over a coaxial tone bus. It has one output, `gate`, which turns an external 22 kHz oscillator on and off. It does not make the carrier itself. A request carries a length, a burst select and a buffer of up to six bytes. The block captures the request and keeps the carrier off for a settling interval. It then sends each byte as nine three-tick symbols: eight data bits, most significant first, and a parity bit. A request with length zero sends a short tone burst instead. Burst A is a solid block of carrier. Burst B is a run of nine '1' symbols.

All timing comes from a fixed tick. The tick is `TICK_CYCLES` system clocks long, about 500 µs. The default of 24012 suits a 48 MHz clock, because it equals twelve times 2001 counts of a 4 MHz base.

A symbol takes three ticks:
- Tick one keeps the carrier off.
- Tick two turns it on.
- Tick three keeps it on for a '0' and turns it off for a '1'.

The block reports `busy` while it works. It pulses `done` once when the message ends and `err` once when a length is refused. The sequencer moves through these states:
- `ST_IDLE` goes to `ST_SETTLE` when a request is accepted.
- `ST_SETTLE` goes to `ST_TONE` for burst A, or to `ST_GAP` for anything else.
- `ST_TONE` goes to `ST_FINISH`.
- `ST_GAP` goes to `ST_MARK`, and `ST_MARK` goes to `ST_TAIL`.
- `ST_TAIL` goes back to `ST_GAP` for the next symbol, or to `ST_FINISH` after the last one.
- `ST_FINISH` goes to `ST_IDLE`.

Top module: `tonebus_tx`

## Requirements
- R1: After reset, `gate`, `busy`, `done` and `err` are all low.
- R2: Every interval the block produces is a whole number of ticks, and each tick is exactly `TICK_CYCLES` clock cycles long.
- R3: A request is accepted in the cycle it is seen with `start` high while the block is idle. `busy` rises in the next cycle. `gate` then stays low for `SETTLE_TICKS` ticks (default 15) before the first symbol or burst.
- R4: Each symbol takes three ticks: carrier off, then carrier on, then carrier on for a '0' or off for a '1'.
- R5: A message of `len` bytes (3 to 6) sends bytes in lane order, starting with byte 0 at `msg[7:0]`, then byte 1 at `msg[15:8]`, and so on. Within each byte, bit 7 goes first.
- R6: The ninth symbol of each byte is a parity bit. It is '1' when the byte holds an even number of ones, and '0' otherwise.
- R7: With `len` = 0 and `burst_sel` = 0, the block sends burst A: `gate` stays high for `BURST_TICKS` ticks (default 25) in a row after the settle.
- R8: With `len` = 0 and `burst_sel` = 1, the block sends burst B: nine '1' symbols after the settle.
- R9: A request with a nonzero length outside 3 to 6 (that is 1, 2 or 7) makes `err` high for exactly one cycle, in the cycle after the request. Nothing is sent, and `busy` stays low.
- R10: A `start` seen while `busy` is high is ignored. The running transmission is unchanged, and `err` stays low.
- R11: `done` is high for exactly one cycle, in the first cycle after the final tick of the last symbol or burst. In that cycle `gate` is low and `busy` is still high. `busy` falls in the next cycle.
- R12: `len`, `burst_sel` and `msg` are captured when a request is accepted. Changing them later has no effect on the transmission in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled on the rising edge |
| len | input | LEN_W (3) | Message length in bytes; 0 selects a tone burst |
| burst_sel | input | 1 | Burst choice when `len` is 0: 0 selects A, 1 selects B |
| msg | input | MAX_BYTES*8 (48) | Message buffer; byte i is in bits [8i+7:8i] |
| gate | output | 1 | Carrier enable for the external 22 kHz oscillator |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse when a length is refused |

## Verification
The bench builds the block with `TICK_CYCLES` = 4 and keeps every other parameter at its default. A full six-byte message then lasts about 700 cycles, which makes it practical to compare every cycle of `gate` against a waveform the bench computes from the symbol rules.

The bench sweeps:
- every legal length, each with four byte patterns;
- both bursts;
- every illegal length;
- a transmission that is disturbed by a second request and changed buffer contents.

Because the tick is short, the bench can check the settle window and the tick boundaries down to the exact clock cycle.

// File: rtl/tonebus_pkg.sv
package tonebus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_TONE,
        ST_GAP,
        ST_MARK,
        ST_TAIL,
        ST_FINISH
    } tb_state_t;

    typedef enum logic [1:0] {
        KIND_MSG,
        KIND_BURST_A,
        KIND_BURST_B
    } tb_kind_t;

    localparam int PARITY_SLOT = 8;

endpackage

// File: rtl/tonebus_ticker.sv
module tonebus_ticker #(
    parameter int TICK_CYCLES = 24012
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(TICK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tonebus_framer.sv
module tonebus_framer #(
    parameter int MAX_BYTES = 6,
    parameter int LEN_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   burst_b,
    input  logic [LEN_W-1:0]       len,
    input  logic [MAX_BYTES*8-1:0] data,
    input  logic                   advance,
    output logic                   cur_bit,
    output logic                   last_bit
);
    import tonebus_pkg::*;

    localparam int IW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    logic [MAX_BYTES-1:0][7:0] lane_q;
    logic [MAX_BYTES-1:0]      par_w;
    logic [3:0]                slot_q;
    logic [IW-1:0]             lane_idx_q;
    logic [IW-1:0]             lane_last_q;
    logic                      burst_q;
    logic [7:0]                cur_lane;

    genvar g;
    generate
        for (g = 0; g < MAX_BYTES; g++) begin : g_par
            assign par_w[g] = ~(^lane_q[g]);
        end
    endgenerate

    assign cur_lane = lane_q[lane_idx_q];

    always_comb begin
        if (burst_q) begin
            cur_bit = 1'b1;
        end else if (slot_q == 4'(PARITY_SLOT)) begin
            cur_bit = par_w[lane_idx_q];
        end else begin
            cur_bit = cur_lane[3'd7 - slot_q[2:0]];
        end
    end

    assign last_bit = (slot_q == 4'(PARITY_SLOT)) && (lane_idx_q == lane_last_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q      <= '0;
            slot_q      <= '0;
            lane_idx_q  <= '0;
            lane_last_q <= '0;
            burst_q     <= 1'b0;
        end else if (load) begin
            lane_q      <= data;
            slot_q      <= '0;
            lane_idx_q  <= '0;
            lane_last_q <= burst_b ? '0 : IW'(len - LEN_W'(1));
            burst_q     <= burst_b;
        end else if (advance) begin
            if (slot_q == 4'(PARITY_SLOT)) begin
                slot_q     <= '0;
                lane_idx_q <= lane_idx_q + 1'b1;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tonebus_seq.sv
module tonebus_seq #(
    parameter int SETTLE_TICKS = 15,
    parameter int BURST_TICKS  = 25,
    parameter int MIN_BYTES    = 3,
    parameter int MAX_BYTES    = 6,
    parameter int LEN_W        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             burst_sel,
    input  logic             tick,
    input  logic             cur_bit,
    input  logic             last_bit,
    output logic             run,
    output logic             load,
    output logic             burst_b,
    output logic             advance,
    output logic             gate,
    output logic             busy,
    output logic             done,
    output logic             err
);
    import tonebus_pkg::*;

    localparam int TMAX = (SETTLE_TICKS > BURST_TICKS) ? SETTLE_TICKS : BURST_TICKS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_TICKS - 1);
    localparam logic [TW-1:0] BURST_LAST  = TW'(BURST_TICKS - 1);

    tb_state_t     state_q, state_d;
    tb_kind_t      kind_q;
    logic [TW-1:0] tcnt_q;
    logic          err_q;
    logic          is_burst, len_ok, accept, refuse;

    assign is_burst = (len == '0);
    assign len_ok   = (len >= LEN_W'(MIN_BYTES)) && (len <= LEN_W'(MAX_BYTES));
    assign accept   = (state_q == ST_IDLE) && start && (is_burst || len_ok);
    assign refuse   = (state_q == ST_IDLE) && start && !is_burst && !len_ok;
    assign load     = accept;
    assign burst_b  = is_burst && burst_sel;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SETTLE;
            ST_SETTLE: if (tick && tcnt_q == SETTLE_LAST)
                           state_d = (kind_q == KIND_BURST_A) ? ST_TONE : ST_GAP;
            ST_TONE:   if (tick && tcnt_q == BURST_LAST) state_d = ST_FINISH;
            ST_GAP:    if (tick) state_d = ST_MARK;
            ST_MARK:   if (tick) state_d = ST_TAIL;
            ST_TAIL:   if (tick) state_d = last_bit ? ST_FINISH : ST_GAP;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= KIND_MSG;
            tcnt_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= refuse;
            if (accept) begin
                kind_q <= !is_burst ? KIND_MSG : (burst_sel ? KIND_BURST_B : KIND_BURST_A);
            end
            if (state_d != state_q) begin
                tcnt_q <= '0;
            end else if (tick) begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        gate    = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        run     = 1'b1;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                run  = 1'b0;
            end
            ST_SETTLE: ;
            ST_TONE:   gate = 1'b1;
            ST_GAP:    ;
            ST_MARK:   gate = 1'b1;
            ST_TAIL: begin
                gate    = !cur_bit;
                advance = tick;
            end
            ST_FINISH: begin
                done = 1'b1;
                run  = 1'b0;
            end
        endcase
    end

    assign err = err_q;
endmodule

// File: rtl/tonebus_tx.sv
module tonebus_tx #(
    parameter int TICK_CYCLES  = 24012,
    parameter int SETTLE_TICKS = 15,
    parameter int BURST_TICKS  = 25,
    parameter int MIN_BYTES    = 3,
    parameter int MAX_BYTES    = 6,
    localparam int LEN_W       = $clog2(MAX_BYTES + 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LEN_W-1:0]       len,
    input  logic                   burst_sel,
    input  logic [MAX_BYTES*8-1:0] msg,
    output logic                   gate,
    output logic                   busy,
    output logic                   done,
    output logic                   err
);
    logic run, tick, load, burst_b, advance, cur_bit, last_bit;

    tonebus_ticker #(.TICK_CYCLES(TICK_CYCLES)) u_ticker (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    tonebus_framer #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .load(load), .burst_b(burst_b),
        .len(len), .data(msg), .advance(advance),
        .cur_bit(cur_bit), .last_bit(last_bit)
    );

    tonebus_seq #(
        .SETTLE_TICKS(SETTLE_TICKS), .BURST_TICKS(BURST_TICKS),
        .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .len(len), .burst_sel(burst_sel),
        .tick(tick), .cur_bit(cur_bit), .last_bit(last_bit),
        .run(run), .load(load), .burst_b(burst_b), .advance(advance),
        .gate(gate), .busy(busy), .done(done), .err(err)
    );
endmodule

// File: rtl/tonebus_tx_checks.sv
module tonebus_tx_checks #(
    parameter int TICK_CYCLES  = 24012,
    parameter int SETTLE_TICKS = 15,
    parameter int BURST_TICKS  = 25
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic gate,
    input logic busy,
    input logic done,
    input logic err
);
    localparam int SETTLE_CYC = SETTLE_TICKS * TICK_CYCLES;
    localparam int BURST_CYC  = BURST_TICKS * TICK_CYCLES;

    int busy_age;
    int gate_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_age <= 0;
            gate_run <= 0;
        end else begin
            busy_age <= !busy ? 0 : ((busy_age < SETTLE_CYC) ? busy_age + 1 : busy_age);
            gate_run <= !gate ? 0 : ((gate_run <= BURST_CYC) ? gate_run + 1 : gate_run);
        end
    end

    a_r1_gate_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !gate);

    a_r3_settle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_age < SETTLE_CYC) |-> !gate);

    a_r3_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r7_tone_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (gate_run < BURST_CYC));

    a_r9_err_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!gate && busy));

    a_r11_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind tonebus_tx tonebus_tx_checks #(
    .TICK_CYCLES(TICK_CYCLES), .SETTLE_TICKS(SETTLE_TICKS), .BURST_TICKS(BURST_TICKS)
) u_checks (
    .clk(clk), .rst_n(rst_n), .start(start), .gate(gate),
    .busy(busy), .done(done), .err(err)
);

// File: tb/tonebus_tx_test.sv
module tonebus_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int T          = 4;
    localparam int SETTLE     = 15;
    localparam int BURST      = 25;
    localparam int NB         = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [2:0]    len_i = '0;
    logic          sel_i = 1'b0;
    logic [NB*8-1:0] msg_i = '0;
    logic          gate, busy, done, err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic exp_tk [0:255];
    int   n_tk;

    tonebus_tx #(.TICK_CYCLES(T)) uut (
        .clk(clk), .rst_n(rst_n), .start(start_i), .len(len_i), .burst_sel(sel_i),
        .msg(msg_i), .gate(gate), .busy(busy), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic put_sym(input bit b);
        exp_tk[n_tk]   = 1'b0;
        exp_tk[n_tk+1] = 1'b1;
        exp_tk[n_tk+2] = !b;
        n_tk += 3;
    endtask

    task automatic build(input int ln, input bit sel, input logic [NB*8-1:0] d);
        n_tk = 0;
        for (int i = 0; i < SETTLE; i++) begin exp_tk[n_tk] = 1'b0; n_tk++; end
        if (ln == 0 && !sel) begin
            for (int i = 0; i < BURST; i++) begin exp_tk[n_tk] = 1'b1; n_tk++; end
        end else if (ln == 0) begin
            for (int i = 0; i < 9; i++) put_sym(1'b1);
        end else begin
            for (int by = 0; by < ln; by++) begin
                logic [7:0] v;
                int ones;
                v = d[by*8 +: 8];
                ones = 0;
                for (int b = 7; b >= 0; b--) begin
                    put_sym(v[b]);
                    ones += int'(v[b]);
                end
                put_sym((ones % 2) == 0);
            end
        end
    endtask

    function automatic logic [7:0] pat(input int p, input int i);
        case (p)
            0: pat = 8'h00;
            1: pat = 8'hFF;
            2: pat = 8'hA5 ^ 8'(i);
            default: pat = 8'(i * 37 + 11);
        endcase
    endfunction

    task automatic send(input int ln, input bit sel, input logic [NB*8-1:0] d,
                        input bit disturb, input string tag);
        int settle_bad = -1, sym_bad = -1, busy_bad = -1, err_seen = 0;
        int last;
        build(ln, sel, d);
        last = n_tk * T;
        @(negedge clk);
        len_i = 3'(ln); sel_i = sel; msg_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k <= last + 1; k++) begin
            if (err) err_seen++;
            if (k < last) begin
                if (gate !== exp_tk[k / T]) begin
                    if (k < SETTLE * T) begin if (settle_bad < 0) settle_bad = k; end
                    else if (sym_bad < 0) sym_bad = k;
                end
                if (busy !== 1'b1 || done !== 1'b0) if (busy_bad < 0) busy_bad = k;
            end else if (k == last) begin
                check(done === 1'b1 && gate === 1'b0 && busy === 1'b1,
                      {"R11 done cycle ", tag}, int'({done, gate, busy}), 3'b101);
            end else begin
                check(done === 1'b0 && busy === 1'b0,
                      {"R11 release ", tag}, int'({done, busy}), 0);
            end
            if (disturb && k == 20 * T) begin
                start_i = 1'b1; len_i = 3'd3; sel_i = ~sel; msg_i = ~d;
            end
            if (disturb && k == 20 * T + 1) start_i = 1'b0;
            if (k <= last) @(negedge clk);
        end
        check(settle_bad < 0, {"R3 settle quiet ", tag}, settle_bad, -1);
        check(sym_bad < 0, {"R2 R4 R5 R6 R7 R8 R12 waveform ", tag}, sym_bad, -1);
        check(busy_bad < 0, {"R3 busy window ", tag}, busy_bad, -1);
        if (disturb) check(err_seen == 0, {"R10 no err when busy ", tag}, err_seen, 0);
    endtask

    task automatic refuse(input int ln);
        int bad = 0;
        @(negedge clk);
        len_i = 3'(ln); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(err === 1'b1, $sformatf("R9 err pulse len %0d", ln), int'(err), 1);
        for (int k = 0; k < 3 * T + 2; k++) begin
            @(negedge clk);
            if (err !== 1'b0 || busy !== 1'b0 || gate !== 1'b0) bad++;
        end
        check(bad == 0, $sformatf("R9 nothing sent len %0d", ln), bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(gate === 1'b0 && busy === 1'b0 && done === 1'b0 && err === 1'b0,
              "R1 reset state", int'({gate, busy, done, err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(gate === 1'b0 && busy === 1'b0, "R1 after release", int'({gate, busy}), 0);

        for (int ln = 3; ln <= NB; ln++) begin
            for (int p = 0; p < 4; p++) begin
                logic [NB*8-1:0] d;
                for (int i = 0; i < NB; i++) d[i*8 +: 8] = pat(p, i + ln);
                send(ln, 1'b0, d, 1'b0, $sformatf("R5 len %0d pattern %0d", ln, p));
            end
        end
        send(0, 1'b0, '0, 1'b0, "R7 burst A");
        send(0, 1'b1, '0, 1'b0, "R8 burst B");
        refuse(1);
        refuse(2);
        refuse(7);
        send(5, 1'b0, 48'h0123_4567_89AB, 1'b1, "R10 R12 disturbed message");
        send(0, 1'b0, '0, 1'b1, "R10 disturbed burst A");
        send(0, 1'b1, '0, 1'b1, "R10 disturbed burst B");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule